// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read engine behind a multiplexed address/data NOR-style memory port. When chip enable and the address strobe are both low on a rising clock edge, it captures a start word address and the burst settings from a 16-bit read configuration word. It then waits a programmable number of clocks and streams words from a synchronous word array. The word address advances linearly for each data beat. A WAIT output tells the host whether the word currently on the output is valid.

The configuration word selects the first-access latency, the burst length (4, 8 or 16 words, or continuous) and whether a finite burst wraps inside its aligned segment or runs across it. It also selects whether each word is held for one clock or two, whether WAIT leads the data by one clock, and the active level of WAIT. Raising output enable suspends the burst with all of its state frozen. Lowering it again resumes from the same word. A non-array read (status or identifier) repeats one word on every clock once the latency has passed. The array has a plain write port used to load its contents.

Top module: `burst_rd_seq`

## Requirements
- R1: On a rising edge with `ce_n` and `adv_n` both low, the block captures `addr_in`, `nonarray`, `alt_word` and the configuration fields at bits [13:11], 9, 8, 3 and [2:0]. Changes to these inputs after that edge have no effect on the burst. A rising edge with `ce_n` high ends any burst, and WAIT then shows its inactive level.
- R2: The first word appears on `dout` after the latency-count edge that follows the capture edge, where the count comes from bits [13:11]. Codes 0 and 1 behave as 2.
- R3: Words follow a linear sequence. Bits [2:0] select the length: 3'b001 gives 4 words, 3'b010 gives 8, 3'b011 gives 16, and any other code gives a continuous burst.
- R4: With bit 3 clear, a finite burst wraps inside the aligned segment of its own length. With bit 3 set, it runs on past the segment boundary. Continuous bursts always increment, and all addresses roll over at the array depth.
- R5: A finite array burst delivers exactly its length in words. After that, WAIT is asserted while `oe_n` stays low.
- R6: With bit 9 clear, each word is presented for one clock. With bit 9 set, each word is presented for two clocks.
- R7: WAIT is asserted while the latency runs and deasserted while a valid word is presented. With bit 8 set, every WAIT change happens one clock before the matching data change.
- R8: When bit 10 is set, WAIT is active high; when it is clear, WAIT is active low. This bit is applied live. WAIT sits at its inactive level while `ce_n` or `oe_n` is high, and when no burst has started.
- R9: While `oe_n` is high, `dout`, the address, the latency count and the beat position are frozen. After `oe_n` falls, the burst continues from the same word.
- R10: A non-array read presents the captured `alt_word` on every clock after the latency and never ends.
- R11: Configuration bits 7 and 6 have no effect on `dout` or `wait_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address strobe, active low |
| oe_n | input | 1 | Output enable, active low; high suspends the burst |
| addr_in | input | AW | Start word address |
| cfg | input | 16 | Read configuration word |
| nonarray | input | 1 | Selects a non-array read of `alt_word` |
| alt_word | input | DW | Word repeated in a non-array read |
| ld_en | input | 1 | Array write enable |
| ld_addr | input | AW | Array write address |
| ld_data | input | DW | Array write data |
| dout | output | DW | Read data |
| wait_o | output | 1 | WAIT, polarity set by configuration bit 10 |

## Verification
The assertions assume that the address strobe is pulsed only while chip enable is low. They also assume that the array is not written during a burst, so that a frozen or repeated output reflects only the sequencer state. The stimulus loads the array while chip enable is high and then issues every burst as a one-clock strobe. After the strobe it scrambles all other inputs, keeping only the WAIT polarity bit, and it ends each burst by raising chip enable. Suspension windows are opened by raising output enable alone, with the strobe held high.

// File: rtl/brs_pkg.sv
// Package: shared types and configuration decoding for the burst read sequencer.
// Assumes the configuration word layout described in the brief.
package brs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LAT  = 2'd1,
        PH_DATA = 2'd2,
        PH_END  = 2'd3
    } phase_t;

    // Burst settings captured at the address strobe.
    typedef struct packed {
        logic [2:0] lat;     // effective first-access latency, 2..7
        logic       dhold;   // present each word for two clocks
        logic       wearly;  // WAIT leads data by one clock
        logic       nowrap;  // cross segment boundaries
        logic [1:0] blsel;   // 0:4 words 1:8 words 2:16 words 3:continuous
    } burst_cfg_t;

    localparam logic [2:0] LAT_MIN = 3'd2;
    localparam logic [1:0] BL_CONT = 2'd3;

    // Clamp latency codes below the minimum.
    function automatic logic [2:0] eff_latency(input logic [2:0] code);
        return (code < LAT_MIN) ? LAT_MIN : code;
    endfunction

    // Map the length code to a segment-size selector.
    function automatic logic [1:0] bl_select(input logic [2:0] code);
        case (code)
            3'b001:  return 2'd0;
            3'b010:  return 2'd1;
            3'b011:  return 2'd2;
            default: return BL_CONT;
        endcase
    endfunction

endpackage

// File: rtl/brs_addr_step.sv
// Next-address generator. For each segment size it builds a candidate that
// increments inside the aligned segment, and it also builds a plain increment.
// The selector and the no-wrap flag pick the result. Assumes AW >= 4.
module brs_addr_step #(
    parameter int AW = 6
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    blsel,
    input  logic          nowrap,
    output logic [AW-1:0] nxt
);
    localparam int NSEL = 4;

    logic [AW-1:0] cand [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_cand
        if (g < NSEL - 1) begin : g_wrap
            localparam int SW = g + 2;
            // increment low SW bits only, upper bits fixed
            assign cand[g] = {cur[AW-1:SW], cur[SW-1:0] + SW'(1)};
        end else begin : g_lin
            assign cand[g] = cur + AW'(1);
        end
    end

    // pick the linear increment when wrapping is disabled
    always_comb nxt = nowrap ? cand[NSEL-1] : cand[blsel];

endmodule

// File: rtl/brs_array.sv
// Synchronous word array model. It has one write port for loading, and a
// read port whose registered output is the data output register. The output
// register holds its value when no read is requested.
module brs_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // array write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // registered read, held when idle
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (re) q <= mem[raddr];
    end

endmodule

// File: rtl/brs_ctrl.sv
// Burst control. Captures address and settings at the strobe, counts latency,
// steps beats with optional two-clock hold, ends finite bursts and produces the
// internal WAIT request. All state freezes while oe_n is high.
// Assumes adv_n is pulsed only while ce_n is low.
module brs_ctrl #(
    parameter int AW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                adv_n,
    input  logic                oe_n,
    input  logic [AW-1:0]       addr_in,
    input  brs_pkg::burst_cfg_t cfg_in,
    input  logic                na_in,
    output brs_pkg::phase_t     phase,
    output logic                na_q,
    output logic                rd_en,
    output logic [AW-1:0]       rd_addr,
    output logic                wait_act
);
    import brs_pkg::*;

    localparam int BW = 4;

    burst_cfg_t    cfg_q;
    logic [2:0]    lat_cnt;
    logic [BW-1:0] beat;
    logic          hold;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] start_q;
    logic [AW-1:0] nxt_addr;
    logic [BW-1:0] beat_last;
    logic          finite;
    logic          last_beat;
    logic          hold_now;
    logic          step;
    logic          strobe;
    logic          live;
    logic          valid_next;

    brs_addr_step #(.AW(AW)) step_i (
        .cur    (addr_q),
        .blsel  (cfg_q.blsel),
        .nowrap (cfg_q.nowrap),
        .nxt    (nxt_addr)
    );

    // derived beat bookkeeping
    always_comb begin
        beat_last = BW'((5'd4 << cfg_q.blsel) - 5'd1);
        finite    = (cfg_q.blsel != BL_CONT) && !na_q;
        last_beat = finite && (beat == beat_last);
        hold_now  = cfg_q.dhold && !hold;
        step      = !hold_now && !last_beat;
        strobe    = !ce_n && !adv_n;
        live      = !ce_n && adv_n && !oe_n;
    end

    // array read request and address
    always_comb begin
        rd_en   = live && (((phase == PH_LAT) && (lat_cnt == 3'd0)) ||
                           ((phase == PH_DATA) && step));
        rd_addr = (phase == PH_LAT) ? addr_q : nxt_addr;
    end

    // burst state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cfg_q   <= '0;
            na_q    <= 1'b0;
            lat_cnt <= '0;
            beat    <= '0;
            hold    <= 1'b0;
            addr_q  <= '0;
            start_q <= '0;
        end else if (ce_n) begin
            phase <= PH_IDLE;
        end else if (strobe) begin
            phase   <= PH_LAT;
            cfg_q   <= cfg_in;
            na_q    <= na_in;
            lat_cnt <= cfg_in.lat - 3'd1;
            beat    <= '0;
            hold    <= 1'b0;
            addr_q  <= addr_in;
            start_q <= addr_in;
        end else if (!oe_n) begin
            case (phase)
                PH_LAT: begin
                    if (lat_cnt == 3'd0) begin
                        phase <= PH_DATA;
                        hold  <= 1'b0;
                    end else begin
                        lat_cnt <= lat_cnt - 3'd1;
                    end
                end
                PH_DATA: begin
                    if (hold_now) begin
                        hold <= 1'b1;
                    end else if (last_beat) begin
                        phase <= PH_END;
                        hold  <= 1'b0;
                    end else begin
                        hold   <= 1'b0;
                        beat   <= beat + BW'(1);
                        addr_q <= nxt_addr;
                    end
                end
                default: ;
            endcase
        end
    end

    // WAIT request, aligned with or one clock ahead of the data
    always_comb begin
        case (phase)
            PH_LAT:  valid_next = (lat_cnt == 3'd0);
            PH_DATA: valid_next = !(last_beat && !hold_now);
            default: valid_next = 1'b0;
        endcase
        if (ce_n || oe_n || (phase == PH_IDLE))
            wait_act = 1'b0;
        else if (cfg_q.wearly)
            wait_act = !valid_next;
        else
            wait_act = (phase != PH_DATA);
    end

    // R1
    // idle_after_deselect_chk
    idle_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (phase == PH_IDLE) && !wait_act);

    // R9
    // suspend_freeze_chk
    suspend_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && adv_n && oe_n) |=>
            $stable(addr_q) && $stable(lat_cnt) && $stable(beat) && $stable(phase));

    // R4
    // segment_stay_chk
    segment_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_DATA) && !cfg_q.nowrap && finite) |->
            (((addr_q ^ start_q) >> ({1'b0, cfg_q.blsel} + 3'd2)) == '0));

    // R5
    // beat_bound_chk
    beat_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_DATA) && finite) |-> (beat <= beat_last));

endmodule

// File: rtl/burst_rd_seq.sv
// Top of the burst read sequencer. Decodes the configuration word, holds the
// non-array word, selects the output source and applies WAIT polarity live.
// Assumes the array is loaded only while no burst is running.
module burst_rd_seq #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr_in,
    input  logic [15:0]   cfg,
    input  logic          nonarray,
    input  logic [DW-1:0] alt_word,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] dout,
    output logic          wait_o
);
    import brs_pkg::*;

    burst_cfg_t    cfg_now;
    phase_t        phase;
    logic          na_q;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          wait_act;
    logic [DW-1:0] arr_q;
    logic [DW-1:0] alt_q;
    logic          unused_cfg;

    // decode the configuration word
    always_comb begin
        cfg_now.lat    = eff_latency(cfg[13:11]);
        cfg_now.dhold  = cfg[9];
        cfg_now.wearly = cfg[8];
        cfg_now.nowrap = cfg[3];
        cfg_now.blsel  = bl_select(cfg[2:0]);
        unused_cfg     = ^{cfg[15:14], cfg[7:4]};
    end

    brs_ctrl #(.AW(AW)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .adv_n    (adv_n),
        .oe_n     (oe_n),
        .addr_in  (addr_in),
        .cfg_in   (cfg_now),
        .na_in    (nonarray),
        .phase    (phase),
        .na_q     (na_q),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .wait_act (wait_act)
    );

    brs_array #(.AW(AW), .DW(DW)) array_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ld_en),
        .waddr (ld_addr),
        .wdata (ld_data),
        .re    (rd_en),
        .raddr (rd_addr),
        .q     (arr_q)
    );

    // capture the non-array word at the strobe
    always_ff @(posedge clk) begin
        if (!rst_n)                 alt_q <= '0;
        else if (!ce_n && !adv_n)   alt_q <= alt_word;
    end

    // output source and WAIT level
    always_comb begin
        dout   = na_q ? alt_q : arr_q;
        wait_o = cfg[10] ? wait_act : !wait_act;
    end

    // R9
    // dout_frozen_chk
    dout_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && adv_n && oe_n) |=> $stable(dout));

    // R10
    // nonarray_repeat_chk
    nonarray_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (na_q && adv_n && (phase == PH_DATA) && ($past(phase) == PH_DATA)) |->
            $stable(dout));

endmodule

// File: tb/burst_rd_seq_tb.sv
// Sweep bench: every latency code, length code, wrap, hold, lead and polarity
// setting, plus suspension and non-array reads. Expected values are computed
// arithmetically from the requirements.
module burst_rd_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, adv_n, oe_n;
    logic [AW-1:0] addr_in;
    logic [15:0]   cfg;
    logic          nonarray;
    logic [DW-1:0] alt_word;
    logic          ld_en;
    logic [AW-1:0] ld_addr;
    logic [DW-1:0] ld_data;
    logic [DW-1:0] dout;
    logic          wait_o;

    int n_vec  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_rd_seq #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
        .addr_in(addr_in), .cfg(cfg), .nonarray(nonarray), .alt_word(alt_word),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .dout(dout), .wait_o(wait_o)
    );

    function automatic logic [15:0] memval(input int a);
        return 16'((a * 773 + 4660) & 65535);
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // is the word after jj active edges valid
    function automatic bit is_valid(input int j, input int lc, input bit dh,
                                    input int n, input bit na);
        int b;
        if (j < lc) return 1'b0;
        b = (j - lc) / (dh ? 2 : 1);
        if (na || n == 0) return 1'b1;
        return b < n;
    endfunction

    task automatic run_burst(input logic [15:0] c, input int st, input bit na,
                             input int sus_at, input int sus_len,
                             input logic [15:0] alt);
        int lc, n, tlen, jj, b, ea;
        bit dh, wd, bw, wp, v0, v1, act;
        logic [15:0] prev;
        string dtag;
        lc = (c[13:11] < 3'd2) ? 2 : int'(c[13:11]);
        case (c[2:0])
            3'b001:  n = 4;
            3'b010:  n = 8;
            3'b011:  n = 16;
            default: n = 0;
        endcase
        dh = c[9]; wd = c[8]; bw = c[3]; wp = c[10];
        dtag = na ? "R10 repeated word" :
               ((c[7:6] != 2'b00) ? "R2 R3 R4 R6 R1 R11 data" : "R2 R3 R4 R6 R1 data");
        tlen = lc + (dh ? 2 : 1) * ((n == 0 || na) ? 20 : n + 2) + 2;
        @(negedge clk);
        ce_n = 1'b0; adv_n = 1'b0; oe_n = 1'b0;
        addr_in = AW'(st); cfg = c; nonarray = na; alt_word = alt;
        @(negedge clk);
        // scramble everything but the polarity bit: captured values must rule
        adv_n = 1'b1; cfg = c ^ 16'hFBFF; nonarray = !na; alt_word = ~alt;
        addr_in = ~AW'(st);
        jj = 0;
        for (int k = 0; k <= tlen + sus_len; k++) begin
            if (k > 0) begin
                oe_n = (sus_len > 0) && (k > sus_at) && (k <= sus_at + sus_len);
                @(posedge clk);
                if (!oe_n) jj++;
                @(negedge clk);
            end
            if (oe_n) begin
                chk({15'd0, wait_o}, {15'd0, !wp}, "R9 R8 wait inactive in suspend");
                chk(dout, prev, "R9 dout frozen in suspend");
            end else begin
                v0  = is_valid(jj, lc, dh, n, na);
                v1  = is_valid(jj + 1, lc, dh, n, na);
                act = wd ? !v1 : !v0;
                chk({15'd0, wait_o}, {15'd0, wp ? act : !act}, "R7 R5 R8 wait");
                if (v0) begin
                    b = (jj - lc) / (dh ? 2 : 1);
                    if (!bw && n != 0) ea = (st & ~(n - 1)) | ((st + b) & (n - 1));
                    else               ea = (st + b) % DEPTH;
                    chk(dout, na ? alt : memval(ea), dtag);
                end
            end
            prev = dout;
        end
        ce_n = 1'b1; oe_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk({15'd0, wait_o}, {15'd0, !wp}, "R1 R8 idle wait level");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [2:0]  blc;
        logic [15:0] c;
        int it;
        rst_n = 1'b0; ce_n = 1'b1; adv_n = 1'b1; oe_n = 1'b1;
        addr_in = '0; cfg = '0; nonarray = 1'b0; alt_word = '0;
        ld_en = 1'b0; ld_addr = '0; ld_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dout, 16'h0000, "R8 reset dout");
        chk({15'd0, wait_o}, 16'd1, "R8 reset wait inactive low-active");
        for (int a = 0; a < DEPTH; a++) begin
            ld_en = 1'b1; ld_addr = AW'(a); ld_data = memval(a);
            @(negedge clk);
        end
        ld_en = 1'b0;

        it = 0;
        for (int lc = 0; lc < 8; lc++) begin
            for (int bi = 0; bi < 5; bi++) begin
                case (bi)
                    0: blc = 3'b001;
                    1: blc = 3'b010;
                    2: blc = 3'b011;
                    3: blc = 3'b111;
                    default: blc = 3'b101;
                endcase
                for (int m = 0; m < 16; m++) begin
                    c = {2'b00, 3'(lc), 1'(m >> 3), 1'(m >> 1), 1'(m >> 2),
                         2'(it), 2'b00, 1'(m), blc};
                    run_burst(c, (it * 13 + 5) % DEPTH, 1'b0, 0, 0, 16'h0);
                    it++;
                end
            end
        end

        // R9 suspension during latency and during data
        run_burst({2'b00, 3'd5, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 3'b010}, 10, 1'b0, 2, 3, 16'h0);
        run_burst({2'b00, 3'd3, 1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 1'b1, 3'b001}, 62, 1'b0, 6, 4, 16'h0);
        run_burst({2'b00, 3'd4, 1'b1, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0, 3'b111}, 33, 1'b0, 8, 2, 16'h0);
        // R10 non-array reads, finite length code ignored
        run_burst({2'b00, 3'd2, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 3'b001}, 7, 1'b1, 0, 0, 16'hC3A5);
        run_burst({2'b00, 3'd6, 1'b0, 1'b1, 1'b1, 2'b10, 2'b00, 1'b1, 3'b011}, 40, 1'b1, 9, 3, 16'h5E71);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule